// File: doc/BRIEF.md
# Indexed-Colour Display Register File

This block is the control register file of a simple indexed-colour framebuffer. A processor writes it through a single-cycle memory-mapped strobe with byte, halfword or word size. It stores a 256-entry colour lookup table with red, green and blue components of 8 bits each. It also stores the display width and height, which software assembles from byte writes landing at odd bit positions. The scanout engine reads the lookup table through a separate combinational read port.

Each write is split into byte lanes, and each lane is decoded on its own offset within a 16-bit space. Every write raises a sticky full-refresh request, which the scanout side clears with an acknowledge. The block reports whether the geometry is usable, that is, both width and height are nonzero. It also issues a one-cycle resize pulse after any write that leaves the geometry usable. Reads of the control space return zero.

Top module: `palgeom_regs`

## Requirements
- R1: Only address bits [15:0] are decoded. Any value on the upper address bits has no effect on which storage a write reaches.
- R2: An offset below 0x0800 selects lookup entry offset[10:3] and component offset[2:0], where 0 is red, 1 is green and 2 is blue. The read port returns the stored components of the entry chosen by `palRdIdx` in the same cycle.
- R3: A lookup-table byte whose offset[2:0] is 3 to 7 changes no stored component.
- R4: A byte at offset 0x0918 replaces width bits [9:2], and a byte at offset 0x0919 replaces width bits [17:10]. All other width bits keep their value, and width bits [1:0] are always zero. The geometry changes only on a write.
- R5: A byte at offset 0x0940 places data bits [7:1] into height bits [6:0]. A byte at offset 0x0941 replaces height bits [14:7].
- R6: `busSize` 0 writes one byte, 1 writes two, and 2 or 3 write four. Lane k carries `busWdata[8k+7:8k]` to offset (addr+k) mod 2^16, so the access is little-endian and wraps at the top of the 16-bit space.
- R7: Every write, including one to an unmapped offset, sets `refreshReq` on the next edge. `refreshReq` stays set until a cycle with `refreshAck` high and no write, and a write in the same cycle as an acknowledge keeps it set.
- R8: A read (`busValid` high, `busWrite` low) returns zero on `busRdata` for every size, and changes no state.
- R9: Reset clears every lookup entry, the width and the height, and sets `refreshReq`.
- R10: `geomValid` is high exactly when width and height are both nonzero. `resizePulse` is high for the one cycle after a write whose result leaves both nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| busAddr | input | ADDR_W | Access address, low 16 bits decoded |
| busWdata | input | DATA_W | Write data, lane 0 in the lowest byte |
| busRdata | output | DATA_W | Read data, always zero |
| refreshAck | input | 1 | Scanout acknowledge of the refresh request |
| palRdIdx | input | 8 | Lookup entry for the scanout read port |
| palRdRed | output | 8 | Red component of the selected entry |
| palRdGreen | output | 8 | Green component of the selected entry |
| palRdBlue | output | 8 | Blue component of the selected entry |
| dispWidth | output | 18 | Display width in pixels |
| dispHeight | output | 15 | Display height in lines |
| geomValid | output | 1 | Width and height both nonzero |
| resizePulse | output | 1 | One-cycle pulse after a write leaving the geometry valid |
| refreshReq | output | 1 | Sticky full-refresh request |

## Verification
The hardest case to reach is a multi-byte write whose lanes fall on different targets. Examples are a word that straddles an unmapped byte and a width field, a word that wraps from offset 0xFFFF to the start of the lookup table, and a word whose fourth lane hits an unused component slot. The stimulus table places word writes at such offsets and then checks every target the lanes touch. A write and an acknowledge in the same cycle is driven directly to check that the write wins. The resize pulse is checked from a reset state, with the height written after the width, so that the pulse appears only on the write that completes a valid geometry.

// File: rtl/palgeom_pkg.sv
package palgeom_pkg;
  localparam int OFF_W     = 16;
  localparam int COMP_W    = 8;
  localparam int IDX_W     = 8;
  localparam int PAL_DEPTH = 1 << IDX_W;
  localparam int NCOMP     = 3;
  localparam int WID_W     = 18;
  localparam int HGT_W     = 15;

  localparam logic [OFF_W-1:0] PAL_END = 16'h0800;
  localparam logic [OFF_W-1:0] WID_LO  = 16'h0918;
  localparam logic [OFF_W-1:0] WID_HI  = 16'h0919;
  localparam logic [OFF_W-1:0] HGT_LO  = 16'h0940;
  localparam logic [OFF_W-1:0] HGT_HI  = 16'h0941;

  // per-lane strobes from decode to storage
  typedef struct packed {
    logic              palWe;
    logic [IDX_W-1:0]  palIdx;
    logic [1:0]        palComp;
    logic              widLoWe;
    logic              widHiWe;
    logic              hgtLoWe;
    logic              hgtHiWe;
    logic [7:0]        byteVal;
  } laneStrobe_t;
endpackage

// File: rtl/palgeom_decode.sv
module palgeom_decode
  import palgeom_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NLANES = DATA_W / 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output laneStrobe_t       strb [NLANES],
  output logic              wrAny
);
  logic [OFF_W-1:0] baseOff;
  logic [3:0]       laneCnt;
  logic             unusedAddrHi;

  assign wrAny        = busValid && busWrite;
  assign baseOff      = busAddr[OFF_W-1:0];
  assign unusedAddrHi = ^busAddr[ADDR_W-1:OFF_W];
  assign laneCnt      = (busSize == 2'd0) ? 4'd1 :
                        (busSize == 2'd1) ? 4'd2 : 4'd4;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic [OFF_W-1:0] off;
    logic             on;
    assign off = baseOff + OFF_W'(l);
    assign on  = wrAny && (4'(l) < laneCnt);

    always_comb begin
      strb[l]         = '0;
      strb[l].byteVal = busWdata[8*l +: 8];
      strb[l].palIdx  = off[10:3];
      strb[l].palComp = off[1:0];
      strb[l].palWe   = on && (off < PAL_END) && (off[2:0] < 3'd3);
      strb[l].widLoWe = on && (off == WID_LO);
      strb[l].widHiWe = on && (off == WID_HI);
      strb[l].hgtLoWe = on && (off == HGT_LO);
      strb[l].hgtHiWe = on && (off == HGT_HI);
    end
  end
endmodule

// File: rtl/palgeom_store.sv
module palgeom_store
  import palgeom_pkg::*;
#(
  parameter int NLANES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strb [NLANES],
  input  logic              wrAny,
  input  logic              refreshAck,
  input  logic [IDX_W-1:0]  palRdIdx,
  output logic [COMP_W-1:0] palRdRed,
  output logic [COMP_W-1:0] palRdGreen,
  output logic [COMP_W-1:0] palRdBlue,
  output logic [WID_W-1:0]  dispWidth,
  output logic [HGT_W-1:0]  dispHeight,
  output logic              geomValid,
  output logic              resizePulse,
  output logic              refreshReq
);
  logic [COMP_W-1:0] palMem [PAL_DEPTH][NCOMP];
  logic [WID_W-1:0]  widNext;
  logic [HGT_W-1:0]  hgtNext;

  // lookup table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < PAL_DEPTH; e++)
        for (int c = 0; c < NCOMP; c++)
          palMem[e][c] <= '0;
    end else begin
      for (int l = 0; l < NLANES; l++)
        if (strb[l].palWe)
          palMem[strb[l].palIdx][strb[l].palComp] <= strb[l].byteVal;
    end
  end

  assign palRdRed   = palMem[palRdIdx][0];
  assign palRdGreen = palMem[palRdIdx][1];
  assign palRdBlue  = palMem[palRdIdx][2];

  // geometry merge, lanes applied in offset order
  always_comb begin
    widNext = dispWidth;
    hgtNext = dispHeight;
    for (int l = 0; l < NLANES; l++) begin
      if (strb[l].widLoWe) widNext[9:2]   = strb[l].byteVal;
      if (strb[l].widHiWe) widNext[17:10] = strb[l].byteVal;
      if (strb[l].hgtLoWe) hgtNext[6:0]   = strb[l].byteVal[7:1];
      if (strb[l].hgtHiWe) hgtNext[14:7]  = strb[l].byteVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispWidth   <= '0;
      dispHeight  <= '0;
      resizePulse <= 1'b0;
      refreshReq  <= 1'b1;
    end else begin
      dispWidth   <= widNext;
      dispHeight  <= hgtNext;
      resizePulse <= wrAny && (widNext != '0) && (hgtNext != '0);
      if (wrAny)           refreshReq <= 1'b1;
      else if (refreshAck) refreshReq <= 1'b0;
    end
  end

  assign geomValid = (dispWidth != '0) && (dispHeight != '0);
endmodule

// File: rtl/palgeom_regs.sv
module palgeom_regs
  import palgeom_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              refreshAck,
  input  logic [7:0]        palRdIdx,
  output logic [7:0]        palRdRed,
  output logic [7:0]        palRdGreen,
  output logic [7:0]        palRdBlue,
  output logic [17:0]       dispWidth,
  output logic [14:0]       dispHeight,
  output logic              geomValid,
  output logic              resizePulse,
  output logic              refreshReq
);
  localparam int NLANES = DATA_W / 8;

  laneStrobe_t strb [NLANES];
  logic        wrAny;

  assign busRdata = '0;

  palgeom_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .busValid (busValid),
    .busWrite (busWrite),
    .busSize  (busSize),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strb     (strb),
    .wrAny    (wrAny)
  );

  palgeom_store #(.NLANES(NLANES)) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrAny       (wrAny),
    .refreshAck  (refreshAck),
    .palRdIdx    (palRdIdx),
    .palRdRed    (palRdRed),
    .palRdGreen  (palRdGreen),
    .palRdBlue   (palRdBlue),
    .dispWidth   (dispWidth),
    .dispHeight  (dispHeight),
    .geomValid   (geomValid),
    .resizePulse (resizePulse),
    .refreshReq  (refreshReq)
  );
endmodule

// File: rtl/palgeom_regs_chk.sv
module palgeom_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic        refreshAck,
  input logic [17:0] dispWidth,
  input logic [14:0] dispHeight,
  input logic        geomValid,
  input logic        resizePulse,
  input logic        refreshReq
);
  AST_REFRESH_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |=> refreshReq); // R7
  AST_REFRESH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !refreshAck) |=> refreshReq); // R7
  AST_REFRESH_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (refreshAck && !(busValid && busWrite)) |=> !refreshReq); // R7
  AST_GEOM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |=> ($stable(dispWidth) && $stable(dispHeight))); // R4
  AST_WIDTH_LSB_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    dispWidth[1:0] == 2'b00); // R4
  AST_RESIZE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    resizePulse |-> $past(busValid && busWrite)); // R10
  AST_RESIZE_GEOM_VALID: assert property (@(posedge clk) disable iff (!rstN)
    resizePulse |-> geomValid); // R10
endmodule

bind palgeom_regs palgeom_regs_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busValid    (busValid),
  .busWrite    (busWrite),
  .refreshAck  (refreshAck),
  .dispWidth   (dispWidth),
  .dispHeight  (dispHeight),
  .geomValid   (geomValid),
  .resizePulse (resizePulse),
  .refreshReq  (refreshReq)
);

// File: tb/tb_palgeom_regs.sv
`timescale 1ns/1ps
module tb_palgeom_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busSize = 2'd0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        refreshAck = 1'b0;
  logic [7:0]  palRdIdx = '0;
  logic [7:0]  palRdRed, palRdGreen, palRdBlue;
  logic [17:0] dispWidth;
  logic [14:0] dispHeight;
  logic        geomValid, resizePulse, refreshReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  palgeom_regs dut (.*);

  typedef struct packed {
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] data;
    logic [17:0] wid;
    logic [14:0] hgt;
    logic [7:0]  idx;
    logic [23:0] rgb;
    logic [7:0]  req;
  } vec_t;

  // expected state after each write, carried from the previous vector
  localparam vec_t VECS [13] = '{
    '{2'd0, 32'h0000_0008, 32'h0000_0011, 18'h0,     15'h0,    8'h01, 24'h110000, 8'd2}, // R2 red of entry 1
    '{2'd1, 32'h0000_0009, 32'h0000_3322, 18'h0,     15'h0,    8'h01, 24'h112233, 8'd6}, // R6 halfword
    '{2'd2, 32'h0000_0010, 32'hDDCC_BBAA, 18'h0,     15'h0,    8'h02, 24'hAABBCC, 8'd3}, // R3 lane 3 unused slot
    '{2'd0, 32'hABCD_0013, 32'h0000_0077, 18'h0,     15'h0,    8'h02, 24'hAABBCC, 8'd1}, // R1 high bits, slot 3
    '{2'd0, 32'h0000_0918, 32'h0000_00FF, 18'h003FC, 15'h0,    8'h02, 24'hAABBCC, 8'd4}, // R4 low byte
    '{2'd0, 32'h0000_0919, 32'h0000_0001, 18'h007FC, 15'h0,    8'h02, 24'hAABBCC, 8'd4}, // R4 high byte
    '{2'd0, 32'hFFFF_0918, 32'h0000_0000, 18'h00400, 15'h0,    8'h02, 24'hAABBCC, 8'd1}, // R1 high bits, width
    '{2'd1, 32'h0000_0940, 32'h0000_0203, 18'h00400, 15'h0101, 8'h02, 24'hAABBCC, 8'd5}, // R5 both bytes
    '{2'd0, 32'h0000_0941, 32'h0000_00FF, 18'h00400, 15'h7F81, 8'h02, 24'hAABBCC, 8'd5}, // R5 high byte
    '{2'd2, 32'h0000_0917, 32'h0000_1234, 18'h00048, 15'h7F81, 8'h02, 24'hAABBCC, 8'd6}, // R6 straddle
    '{2'd3, 32'h0000_FFFE, 32'h4433_2211, 18'h00048, 15'h7F81, 8'h00, 24'h334400, 8'd6}, // R6 wrap
    '{2'd0, 32'h0000_07FA, 32'h0000_005A, 18'h00048, 15'h7F81, 8'hFF, 24'h00005A, 8'd2}, // R2 last entry blue
    '{2'd0, 32'h0000_0800, 32'h0000_0099, 18'h00048, 15'h7F81, 8'hFF, 24'h00005A, 8'd7}  // R7 unmapped
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busSize = sz; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    applyReset();
    // R9 reset state
    chk("R9", "refreshReq", refreshReq, 1);
    chk("R9", "width", dispWidth, 0);
    chk("R9", "height", dispHeight, 0);
    chk("R10", "geomValid", geomValid, 0);
    chk("R10", "resizePulse", resizePulse, 0);
    palRdIdx = 8'h00;
    #0.1 chk("R9", "entry0", {palRdRed, palRdGreen, palRdBlue}, 0);

    // stimulus table walk
    foreach (VECS[i]) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      busWr(VECS[i].size, VECS[i].addr, VECS[i].data);
      palRdIdx = VECS[i].idx;
      #0.1;
      chk(tag, $sformatf("vec%0d width", i), dispWidth, VECS[i].wid);
      chk(tag, $sformatf("vec%0d height", i), dispHeight, VECS[i].hgt);
      chk(tag, $sformatf("vec%0d rgb", i), {palRdRed, palRdGreen, palRdBlue}, VECS[i].rgb);
      chk("R7", $sformatf("vec%0d refresh", i), refreshReq, 1);
    end
    palRdIdx = 8'h01;
    #0.1 chk("R2", "entry1 kept", {palRdRed, palRdGreen, palRdBlue}, 24'h112233);
    chk("R10", "geomValid both nonzero", geomValid, 1);

    // R7 acknowledge and write/ack collision
    refreshAck = 1'b1; @(negedge clk); refreshAck = 1'b0;
    chk("R7", "ack clears", refreshReq, 0);
    @(negedge clk);
    chk("R7", "stays clear", refreshReq, 0);
    refreshAck = 1'b1;
    busWr(2'd0, 32'h0000_0C00, 32'h0);
    chk("R7", "write beats ack", refreshReq, 1);
    @(negedge clk); refreshAck = 1'b0;
    chk("R7", "ack alone clears", refreshReq, 0);

    // R8 reads return zero and change nothing
    for (int s = 0; s < 4; s++) begin
      busValid = 1'b1; busWrite = 1'b0; busSize = 2'(s); busAddr = 32'h0000_0918;
      #0.1 chk("R8", $sformatf("rdata size%0d", s), busRdata, 0);
      @(negedge clk);
      busValid = 1'b0;
    end
    chk("R8", "read no refresh", refreshReq, 0);
    chk("R8", "read keeps width", dispWidth, 18'h00048);

    // R9 reset after traffic
    applyReset();
    palRdIdx = 8'h01;
    #0.1 chk("R9", "entry1 cleared", {palRdRed, palRdGreen, palRdBlue}, 0);
    palRdIdx = 8'hFF;
    #0.1 chk("R9", "entry255 cleared", {palRdRed, palRdGreen, palRdBlue}, 0);
    chk("R9", "width cleared", dispWidth, 0);
    chk("R9", "height cleared", dispHeight, 0);
    chk("R9", "refresh set", refreshReq, 1);

    // R10 geometry valid and resize pulse
    busWr(2'd0, 32'h0000_0918, 32'h01);
    chk("R10", "width only pulse", resizePulse, 0);
    chk("R10", "width only valid", geomValid, 0);
    chk("R4", "width=4", dispWidth, 18'h4);
    busWr(2'd0, 32'h0000_0941, 32'h01);
    chk("R10", "pulse on completion", resizePulse, 1);
    chk("R10", "valid on completion", geomValid, 1);
    chk("R5", "height=0x80", dispHeight, 15'h80);
    @(negedge clk);
    chk("R10", "pulse one cycle", resizePulse, 0);
    busWr(2'd0, 32'h0000_0C00, 32'h0);
    chk("R10", "pulse on unmapped write", resizePulse, 1);
    busWr(2'd0, 32'h0000_0941, 32'h00);
    chk("R10", "no pulse when height zero", resizePulse, 0);
    chk("R10", "invalid when height zero", geomValid, 0);

    done = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule